// File: doc/BRIEF.md
# Free-Running Timer with Coherent Byte Reads

This block is a 16-bit up-counter that runs without stopping. It is read one byte at a time by a small 8-bit processor. The counter advances once for every four cycles of the bus clock. The bus clock is the oscillator divided by two, and the divide-by-four prescaler sits inside the block. Software sees the count through two register pairs, each made of a high byte and a low byte:

- **Primary pair.** Reads of this pair take part in the overflow-flag protocol.
- **Alternate pair.** This pair gives the same view of the count, but reading it never disturbs the flag or the interrupt.

Each pair has its own low-byte latch. Reading the high byte freezes the matching low byte, so a high-then-low sequence returns one consistent 16-bit value even though the counter keeps moving.

When the count passes from 0xFFFF to 0x0000, an overflow flag is set in a status register. The interrupt output is raised whenever that flag is set and the enable bit in the control register is set. Software clears the flag with a two-step sequence:

1. Read the status register while the flag is set. This arms the clear.
2. Read the primary low byte.

The register port is plain:

- **Reads.** `rd_data` is combinational from `addr` during a cycle with `rd_en` high. Read side effects take place at the clock edge that ends that cycle.
- **Writes.** A write with `wr_en` high takes effect at the edge that ends its cycle.
- **Flow control.** Every access completes in one cycle. The port has no back-pressure.

Top module: `frt_timer`

## Requirements
- R1: Reset (asynchronous, `rst_n` low) loads the counter with 0xFFFC and the prescaler with 0. It clears the overflow flag, the clear-arm state, the interrupt enable and both low-byte latches.
- R2: The counter increments by one on every fourth rising clock edge after reset is released (first increment at the 4th edge) and holds its value on all other edges.
- R3: The edge at which the counter steps from 0xFFFF to 0x0000 sets the overflow flag, visible as bit 7 of the status register at address 0x08 (other status bits read 0).
- R4: The control register at 0x09 holds the overflow interrupt enable in bit 5; writes to 0x09 set it from `wr_data[5]`, reads return it in bit 5 with other bits 0, and `irq` is high exactly while the flag and the enable are both 1.
- R5: A status read that sees the flag set arms the clear; a later read of the primary low byte (0x19) clears the flag and disarms; a primary low-byte read without the arm leaves the flag set.
- R6: No read of any address ever changes the counter value.
- R7: For the primary pair (high 0x18, low 0x19): with the latch empty, a low read returns the live low byte. A high read returns the live high byte and captures the live low byte into the latch. Later low reads return that frozen byte until one low read returns it and empties the latch.
- R8: The alternate pair (high 0x1A, low 0x1B) latches the same way with its own latch, independent of the primary pair, and its reads neither change the flag nor the clear-arm state.
- R9: Writes to 0x08, 0x18, 0x19, 0x1A and 0x1B have no effect, and reads of unmapped addresses return 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal bus clock (oscillator / 2) |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read strobe for the current cycle |
| wr_en | input | 1 | Write strobe for the current cycle |
| addr | input | 8 | Register address for read or write |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, combinational from `addr` while `rd_en` is high |
| irq | output | 1 | Overflow interrupt request |

## Verification
The bench drives long runs of random register traffic after each reset, so every run passes through the wrap at the 16th cycle. Its targets are:

- **Status reads racing the wrap.** A design that sets the flag one edge late, or arms from a stale flag, returns the wrong status bit or clears too early.
- **Primary low reads without an arm.** A design that clears the flag on any low read drops the interrupt early.
- **Alternate low reads between the arming status read and the primary low read.** If the two latches or the arm state are shared, the alternate read either empties the wrong latch or consumes the arm.
- **High reads repeated before a low read.** A latch that does not recapture, or that releases on the high read, returns a low byte that does not belong with the high byte just read.

## Summary
A model in the bench tracks every access cycle by cycle and checks each read value and the interrupt level against it.

// File: rtl/frt_pkg.sv
package frt_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int NUM_PAIRS = 2;

  localparam logic [7:0] ADR_STAT   = 8'h08;
  localparam logic [7:0] ADR_CTRL   = 8'h09;
  localparam logic [7:0] ADR_TMR_HI = 8'h18;
  localparam logic [7:0] ADR_TMR_LO = 8'h19;
  localparam logic [7:0] ADR_ALT_HI = 8'h1A;
  localparam logic [7:0] ADR_ALT_LO = 8'h1B;

  localparam int FLAG_BIT = 7;
  localparam int IE_BIT   = 5;

  // pair 0 joins the flag protocol, pair 1 is the side-effect-free view
  function automatic logic [7:0] pair_hi_addr(input int idx);
    return (idx == 0) ? ADR_TMR_HI : ADR_ALT_HI;
  endfunction

  function automatic logic [7:0] pair_lo_addr(input int idx);
    return (idx == 0) ? ADR_TMR_LO : ADR_ALT_LO;
  endfunction
endpackage

// File: rtl/frt_prescaler.sv
module frt_prescaler #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase;

  assign tick = (phase == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      phase <= '0;
    else if (tick)
      phase <= '0;
    else
      phase <= phase + 1'b1;
  end

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R2
endmodule

// File: rtl/frt_counter.sv
module frt_counter #(
  parameter int               CNT_W   = 16,
  parameter logic [CNT_W-1:0] RST_VAL = 16'hFFFC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] TOP = '1;

  assign wrap = tick && (count == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      count <= RST_VAL;
    else if (tick)
      count <= count + 1'b1;
  end

  AST_CNT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count)); // R2
  AST_CNT_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (count == CNT_W'($past(count) + 1'b1))); // R2
endmodule

// File: rtl/frt_byte_latch.sv
module frt_byte_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rd_hi,
  input  logic         rd_lo,
  input  logic [W-1:0] live_lo,
  output logic [W-1:0] lo_view
);
  logic         held;
  logic [W-1:0] frozen;

  assign lo_view = held ? frozen : live_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held   <= 1'b0;
      frozen <= '0;
    end else if (rd_hi) begin
      held   <= 1'b1;
      frozen <= live_lo;
    end else if (rd_lo) begin
      held   <= 1'b0;
    end
  end

  AST_LATCH_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !rd_hi) |=> (frozen == $past(frozen))); // R7
  AST_LATCH_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lo && !rd_hi) |=> !held); // R7
endmodule

// File: rtl/frt_ovf_flag.sv
module frt_ovf_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic wrap,
  input  logic stat_rd,
  input  logic lo_rd,
  output logic flag,
  output logic armed
);
  logic clear_now;

  assign clear_now = lo_rd && armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      armed <= 1'b0;
    end else begin
      if (wrap)
        flag <= 1'b1;
      else if (clear_now)
        flag <= 1'b0;

      if (lo_rd)
        armed <= 1'b0;
      else if (stat_rd && flag)
        armed <= 1'b1;
    end
  end

  AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> flag); // R3
  AST_CLEAR_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(armed && lo_rd)); // R5
endmodule

// File: rtl/frt_timer.sv
module frt_timer #(
  parameter int          PRESCALE = 4,
  parameter logic [15:0] RST_VAL  = 16'hFFFC
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_en,
  input  logic       wr_en,
  input  logic [7:0] addr,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       irq
);
  import frt_pkg::*;

  logic               tick;
  logic [CNT_W-1:0]   count;
  logic               wrap;
  logic               flag;
  logic               armed;
  logic               ovf_ie;
  logic [BYTE_W-1:0]  lo_view [NUM_PAIRS];
  logic [NUM_PAIRS-1:0] rd_hi;
  logic [NUM_PAIRS-1:0] rd_lo;
  logic               stat_rd;

  frt_prescaler #(.DIV(PRESCALE)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  frt_counter #(.CNT_W(CNT_W), .RST_VAL(RST_VAL)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .count(count), .wrap(wrap)
  );

  for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
    assign rd_hi[g] = rd_en && (addr == pair_hi_addr(g));
    assign rd_lo[g] = rd_en && (addr == pair_lo_addr(g));

    frt_byte_latch #(.W(BYTE_W)) u_lat (
      .clk(clk), .rst_n(rst_n),
      .rd_hi(rd_hi[g]), .rd_lo(rd_lo[g]),
      .live_lo(count[BYTE_W-1:0]),
      .lo_view(lo_view[g])
    );
  end

  assign stat_rd = rd_en && (addr == ADR_STAT);

  frt_ovf_flag u_flag (
    .clk(clk), .rst_n(rst_n), .wrap(wrap),
    .stat_rd(stat_rd), .lo_rd(rd_lo[0]),
    .flag(flag), .armed(armed)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ovf_ie <= 1'b0;
    else if (wr_en && (addr == ADR_CTRL))
      ovf_ie <= wr_data[IE_BIT];
  end

  assign irq = flag && ovf_ie;

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      unique case (addr)
        ADR_STAT:   rd_data[FLAG_BIT] = flag;
        ADR_CTRL:   rd_data[IE_BIT]   = ovf_ie;
        ADR_TMR_HI: rd_data = count[CNT_W-1:BYTE_W];
        ADR_TMR_LO: rd_data = lo_view[0];
        ADR_ALT_HI: rd_data = count[CNT_W-1:BYTE_W];
        ADR_ALT_LO: rd_data = lo_view[1];
        default:    rd_data = '0;
      endcase
    end
  end

  AST_ALT_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && (rd_hi[1] || rd_lo[1])) |=> flag); // R8
  AST_ALT_KEEPS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && (rd_hi[1] || rd_lo[1])) |=> armed); // R8
  AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ovf_ie); // R4
endmodule

// File: tb/frt_timer_test.sv
module frt_timer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rd_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       irq;

  int n_chk = 0;
  int n_bad = 0;

  frt_timer uut (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
  );

  always #2 clk = ~clk;

  // bench model built from the requirements
  int         m_pre;
  logic [15:0] m_cnt;
  logic       m_flag, m_arm, m_ie;
  logic       m_held [2];
  logic [7:0] m_lv [2];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pre = 0; m_cnt = 16'hFFFC; m_flag = 0; m_arm = 0; m_ie = 0;
      for (int i = 0; i < 2; i++) begin m_held[i] = 0; m_lv[i] = 0; end
    end else begin
      logic tk, wr_ev, nflag, narm;
      tk = (m_pre == 3);
      wr_ev = tk && (m_cnt == 16'hFFFF);
      nflag = m_flag; narm = m_arm;
      if (rd_en) begin
        case (addr)
          8'h08: if (m_flag) narm = 1;
          8'h18: begin m_held[0] = 1; m_lv[0] = m_cnt[7:0]; end
          8'h19: begin if (m_arm) nflag = 0; narm = 0; m_held[0] = 0; end
          8'h1A: begin m_held[1] = 1; m_lv[1] = m_cnt[7:0]; end
          8'h1B: m_held[1] = 0;
          default: ;
        endcase
      end
      if (wr_en && addr == 8'h09) m_ie = wr_data[5];
      if (wr_ev) nflag = 1;
      m_flag = nflag; m_arm = narm;
      m_pre = tk ? 0 : m_pre + 1;
      if (tk) m_cnt = m_cnt + 16'd1;
    end
  end

  function automatic logic [7:0] exp_read(input logic [7:0] a);
    case (a)
      8'h08: return {m_flag, 7'b0};
      8'h09: return {2'b0, m_ie, 5'b0};
      8'h18, 8'h1A: return m_cnt[15:8];
      8'h19: return m_held[0] ? m_lv[0] : m_cnt[7:0];
      8'h1B: return m_held[1] ? m_lv[1] : m_cnt[7:0];
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // kind: 0 idle, 1 read, 2 write
  task automatic op(input int kind, input logic [7:0] a, input logic [7:0] d, input string tag);
    logic [7:0] e;
    @(negedge clk);
    rd_en = (kind == 1); wr_en = (kind == 2); addr = a; wr_data = d;
    #1;
    if (kind == 1) begin
      e = exp_read(a);
      check(rd_data === e, tag, rd_data, e);
    end
    check(irq === (m_flag && m_ie), {tag, " irq"}, irq, m_flag && m_ie);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rd_en = 0; wr_en = 0;
    rst_n = 0;
    #1;
    check(irq === 1'b0, "R1 irq at reset", irq, 0);
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) op(0, 8'h00, 8'h00, tag);
  endtask

  initial begin
    #800000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset values, independent literal checks
    do_reset();
    op(1, 8'h18, 0, "R1 timer high after reset");
    check(rd_data === 8'hFF, "R1 literal high", rd_data, 8'hFF);
    op(1, 8'h19, 0, "R1 timer low after reset");
    check(rd_data === 8'hFC, "R1 literal low", rd_data, 8'hFC);
    op(1, 8'h08, 0, "R1 status after reset");
    op(1, 8'h09, 0, "R1 control after reset");
    // R2 / R3: run past the wrap
    idle(16, "R2 counting");
    op(1, 8'h08, 0, "R3 flag after wrap");
    check(rd_data === 8'h80, "R3 literal flag", rd_data, 8'h80);
    op(1, 8'h1A, 0, "R2 high byte after wrap");
    op(1, 8'h1B, 0, "R2 low byte after wrap");
    // R4: enable and disable the interrupt
    op(2, 8'h09, 8'h20, "R4 enable write");
    op(1, 8'h09, 0, "R4 control readback");
    check(irq === 1'b1, "R4 irq raised", irq, 1);
    op(2, 8'h09, 8'hDF, "R4 disable write");
    op(0, 0, 0, "R4 irq low");
    op(2, 8'h09, 8'h20, "R4 re-enable");
    // R5: low read without arm leaves flag
    do_reset(); idle(20, "R3 reach wrap");
    op(2, 8'h09, 8'h20, "R4 enable");
    op(1, 8'h19, 0, "R5 unarmed low read");
    op(1, 8'h08, 0, "R5 flag still set");
    // R8: alt reads between arm and clear
    op(1, 8'h1A, 0, "R8 alt high while armed");
    op(1, 8'h1B, 0, "R8 alt low while armed");
    op(1, 8'h08, 0, "R8 flag kept");
    op(1, 8'h19, 0, "R5 clearing low read");
    op(1, 8'h08, 0, "R5 flag cleared");
    check(irq === 1'b0, "R5 irq dropped", irq, 0);
    // R7: frozen low byte
    op(1, 8'h18, 0, "R7 high capture");
    idle(9, "R7 wait");
    op(1, 8'h18, 0, "R7 recapture");
    idle(7, "R7 wait");
    op(1, 8'h1B, 0, "R8 alt low live");
    op(1, 8'h19, 0, "R7 frozen low");
    op(1, 8'h19, 0, "R7 live low after release");
    // R9: ignored writes and unmapped reads
    op(2, 8'h1A, 8'h00, "R9 write alt high");
    op(2, 8'h1B, 8'h00, "R9 write alt low");
    op(2, 8'h18, 8'h00, "R9 write timer high");
    op(2, 8'h19, 8'h00, "R9 write timer low");
    op(2, 8'h08, 8'h00, "R9 write status");
    op(1, 8'h1A, 0, "R9 counter unchanged");
    op(1, 8'h1B, 0, "R9 counter unchanged low");
    op(1, 8'h3C, 0, "R9 unmapped read");
    // random episodes, each crossing the wrap
    for (int ep = 0; ep < 40; ep++) begin
      do_reset();
      for (int k = 0; k < 250; k++) begin
        int r;
        logic [7:0] ra;
        r = $urandom_range(0, 11);
        case (r)
          0, 1: op(1, 8'h08, 0, "R5 rand status");
          2: op(1, 8'h18, 0, "R7 rand timer high");
          3, 4: op(1, 8'h19, 0, "R5 rand timer low");
          5: op(1, 8'h1A, 0, "R8 rand alt high");
          6: op(1, 8'h1B, 0, "R8 rand alt low");
          7: op(2, 8'h09, 8'($urandom), "R4 rand ctrl");
          8: begin
            ra = 8'h18 + 8'($urandom_range(0, 3));
            op(2, ra, 8'($urandom), "R9 rand ignored write");
          end
          9: op(1, 8'h09, 0, "R4 rand ctrl read");
          10: begin
            ra = 8'($urandom_range(32, 255));
            op(1, ra, 0, "R9 rand unmapped");
          end
          default: op(0, 0, 0, "R6 rand idle");
        endcase
      end
    end
    @(negedge clk);
    rd_en = 0; wr_en = 0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule